// File: doc/BRIEF.md
# Output Plug Connection Controller

This block keeps the connection bookkeeping of one isochronous output plug: how many point-to-point connections hold it, whether a broadcast connection is present, and which channel they all share. From the connection state and the node's on-line signal it derives one of four plug states, and only the active state transmits. Connect and disconnect requests arrive as already-decoded write requests. A request that would push the point-to-point count past its limit or below zero is refused and flagged, and so is a second broadcast connection or the removal of one that is absent.

A broadcast connection made on an otherwise unconnected plug takes its channel from a master base value offset by the plug's ordinal, modulo 63, with 63 passed through unchanged. A bus-reset pulse drops every connection. If the plug was transmitting, output stays enabled for a grace window counted in microsecond ticks so that the connection can be rebuilt. The block also decodes the master speed field and its extension into a single speed code and flags illegal combinations.

Top module: `iso_plug_ctrl`

## Requirements
- R1: During and after reset the state is idle (code 0), the point-to-point count is 0, the broadcast flag is 0, and transmit enable and reject are low.
- R2: The state codes are idle=0 (off-line, unconnected), ready=1 (on-line, unconnected), active=2 (on-line, connected) and suspended=3 (off-line, connected). A plug counts as connected when its count is non-zero or its broadcast flag is set. The state, count, flag and channel all change together on the clock edge that registers the cause.
- R3: Outside a grace window, transmit enable is high exactly in the active state. It is low on the cycle after the last connection is removed.
- R4: Request code 0 adds and code 1 removes a point-to-point connection on a 6-bit count. Adding at 63 or removing at 0 leaves the count unchanged and raises reject for one cycle.
- R5: Request code 2 sets and code 3 clears the broadcast flag. Setting it while it is set, or clearing it while it is clear, is rejected and leaves the flag unchanged.
- R6: A point-to-point add on an unconnected plug loads the request channel. Any add on an already connected plug leaves the channel unchanged.
- R7: A broadcast add while the count is 0 sets the channel to 63 if the base is 63, and otherwise to (base + PLUG_IDX) mod 63.
- R8: A bus reset clears the count and the broadcast flag and keeps the channel. A request in the same cycle is ignored and not rejected.
- R9: A bus reset taken while active and on-line keeps transmit enable high for GRACE_US microsecond ticks. Going off-line ends the window on the next cycle.
- R10: On the cycle after on-line falls, transmit enable is low and a connected plug reads suspended. When on-line returns, the plug resumes active.
- R11: Speed field values 0, 1 and 2 give speed codes 0, 1 and 2. With speed field 3, extension values 0, 1 and 2 give codes 3, 4 and 5. A non-zero extension with speed field below 3, or extension 3, flags an error and gives code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Connection request strobe |
| req_op_i | input | 2 | Request code (0 p2p add, 1 p2p remove, 2 broadcast add, 3 broadcast remove) |
| req_chan_i | input | CHAN_W | Channel for a first point-to-point connection |
| bcast_base_i | input | CHAN_W | Broadcast channel base from the master register |
| online_i | input | 1 | Node on-line indication |
| bus_reset_i | input | 1 | Bus reset pulse |
| us_tick_i | input | 1 | One-microsecond tick |
| spd_i | input | 2 | Master speed field |
| xspd_i | input | 2 | Extended speed field |
| tx_en_o | output | 1 | Transmit enable |
| state_o | output | 2 | Plug state code |
| p2p_count_o | output | CNT_W | Point-to-point connection count |
| bcast_o | output | 1 | Broadcast connection flag |
| channel_o | output | CHAN_W | Shared channel |
| req_reject_o | output | 1 | One-cycle pulse for a refused request |
| speed_code_o | output | 3 | Decoded speed code |
| speed_bad_o | output | 1 | Illegal speed combination |

## Verification
The broadcast channel is swept over all 64 base values, so the pass-through at 63, the wrap at 63 and the plain sum are each seen separately. The count is walked from 0 to its ceiling and past both ends, which separates correct saturation from wrap-around. All 16 speed field combinations are applied and tell legal codes from illegal ones. Connection changes are made both on-line and off-line, and bus resets are issued with and without a later drop of the on-line signal. This separates the derived state from the grace-window enable.

// File: rtl/iso_plug_pkg.sv
package iso_plug_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_READY  = 2'd1,
    PS_ACTIVE = 2'd2,
    PS_SUSP   = 2'd3
  } plug_state_e;

  typedef enum logic [1:0] {
    OP_P2P_ADD = 2'd0,
    OP_P2P_DEL = 2'd1,
    OP_BC_ADD  = 2'd2,
    OP_BC_DEL  = 2'd3
  } plug_op_e;

  localparam logic [2:0] SPEED_BAD_CODE = 3'd7;
endpackage

// File: rtl/iso_bchan_calc.sv
module iso_bchan_calc #(
  parameter int CHAN_W   = 6,
  parameter int PLUG_IDX = 0
) (
  input  logic [CHAN_W-1:0] base_i,
  output logic [CHAN_W-1:0] chan_o
);
  localparam int MODV = (1 << CHAN_W) - 1;
  localparam logic [CHAN_W:0] MODV_W = (CHAN_W+1)'(MODV);
  localparam logic [CHAN_W:0] IDX_W  = (CHAN_W+1)'(PLUG_IDX);

  logic [CHAN_W:0] sum_w;
  logic [CHAN_W:0] red_w;

  always_comb begin
    sum_w = {1'b0, base_i} + IDX_W;
    red_w = (sum_w >= MODV_W) ? (sum_w - MODV_W) : sum_w;
    if ({1'b0, base_i} == MODV_W) chan_o = base_i;
    else                          chan_o = red_w[CHAN_W-1:0];
  end
endmodule

// File: rtl/iso_speed_dec.sv
module iso_speed_dec
  import iso_plug_pkg::*;
(
  input  logic [1:0] spd_i,
  input  logic [1:0] xspd_i,
  output logic [2:0] code_o,
  output logic       bad_o
);
  always_comb begin
    bad_o  = 1'b0;
    code_o = {1'b0, spd_i};
    if (spd_i != 2'd3) begin
      if (xspd_i != 2'd0) bad_o = 1'b1;
    end else begin
      if (xspd_i == 2'd3) bad_o = 1'b1;
      else                code_o = 3'd3 + {1'b0, xspd_i};
    end
    if (bad_o) code_o = SPEED_BAD_CODE;
  end
endmodule

// File: rtl/iso_grace_timer.sv
module iso_grace_timer #(
  parameter int GRACE = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clear_i,
  input  logic tick_i,
  output logic busy_o
);
  localparam int CW = $clog2(GRACE + 1);
  localparam logic [CW-1:0] GRACE_V = CW'(GRACE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = GRACE_V;
      cnt_en = 1'b1;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/iso_plug_ctrl.sv
module iso_plug_ctrl
  import iso_plug_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int CHAN_W   = 6,
  parameter int PLUG_IDX = 0,
  parameter int GRACE_US = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic [CHAN_W-1:0] bcast_base_i,
  input  logic              online_i,
  input  logic              bus_reset_i,
  input  logic              us_tick_i,
  input  logic [1:0]        spd_i,
  input  logic [1:0]        xspd_i,
  output logic              tx_en_o,
  output logic [1:0]        state_o,
  output logic [CNT_W-1:0]  p2p_count_o,
  output logic              bcast_o,
  output logic [CHAN_W-1:0] channel_o,
  output logic              req_reject_o,
  output logic [2:0]        speed_code_o,
  output logic              speed_bad_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bc_q, bc_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  plug_state_e       st_q, st_d;
  logic              rej_q, rej_d;
  logic [CHAN_W-1:0] bc_chan;
  logic              was_conn, conn_d;
  logic              grace_busy;

  iso_bchan_calc #(.CHAN_W(CHAN_W), .PLUG_IDX(PLUG_IDX)) u_bchan (
    .base_i (bcast_base_i),
    .chan_o (bc_chan)
  );

  iso_speed_dec u_speed (
    .spd_i  (spd_i),
    .xspd_i (xspd_i),
    .code_o (speed_code_o),
    .bad_o  (speed_bad_o)
  );

  iso_grace_timer #(.GRACE(GRACE_US)) u_grace (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (bus_reset_i && (st_q == PS_ACTIVE) && online_i),
    .clear_i (!online_i),
    .tick_i  (us_tick_i),
    .busy_o  (grace_busy)
  );

  // next-state: every register derives from one evaluation, so the
  // visible fields always change together
  always_comb begin
    cnt_d    = cnt_q;
    bc_d     = bc_q;
    chan_d   = chan_q;
    rej_d    = 1'b0;
    was_conn = (cnt_q != '0) || bc_q;
    if (bus_reset_i) begin
      cnt_d = '0;
      bc_d  = 1'b0;
    end else if (req_valid_i) begin
      unique case (plug_op_e'(req_op_i))
        OP_P2P_ADD: begin
          if (cnt_q == CNT_MAX) rej_d = 1'b1;
          else begin
            cnt_d = cnt_q + 1'b1;
            if (!was_conn) chan_d = req_chan_i;
          end
        end
        OP_P2P_DEL: begin
          if (cnt_q == '0) rej_d = 1'b1;
          else             cnt_d = cnt_q - 1'b1;
        end
        OP_BC_ADD: begin
          if (bc_q) rej_d = 1'b1;
          else begin
            bc_d = 1'b1;
            if (cnt_q == '0) chan_d = bc_chan;
          end
        end
        OP_BC_DEL: begin
          if (!bc_q) rej_d = 1'b1;
          else       bc_d  = 1'b0;
        end
        default: rej_d = 1'b0;
      endcase
    end
    conn_d = (cnt_d != '0) || bc_d;
    if (online_i) st_d = conn_d ? PS_ACTIVE : PS_READY;
    else          st_d = conn_d ? PS_SUSP   : PS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cnt_q  <= '0;
      bc_q   <= 1'b0;
      chan_q <= '0;
      st_q   <= PS_IDLE;
      rej_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bc_q   <= bc_d;
      chan_q <= chan_d;
      st_q   <= st_d;
      rej_q  <= rej_d;
    end
  end

  assign tx_en_o      = (st_q == PS_ACTIVE) || grace_busy;
  assign state_o      = st_q;
  assign p2p_count_o  = cnt_q;
  assign bcast_o      = bc_q;
  assign channel_o    = chan_q;
  assign req_reject_o = rej_q;
endmodule

// File: rtl/iso_plug_ctrl_chk.sv
module iso_plug_ctrl_chk #(
  parameter int CNT_W    = 6,
  parameter int CHAN_W   = 6,
  parameter int PLUG_IDX = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              online_i,
  input logic              bus_reset_i,
  input logic [CHAN_W-1:0] bcast_base_i,
  input logic [1:0]        spd_i,
  input logic [1:0]        xspd_i,
  input logic              tx_en_o,
  input logic [1:0]        state_o,
  input logic [CNT_W-1:0]  p2p_count_o,
  input logic              bcast_o,
  input logic [CHAN_W-1:0] channel_o,
  input logic              req_reject_o,
  input logic              speed_bad_o
);
  localparam int MODV = (1 << CHAN_W) - 1;

  logic [CHAN_W-1:0] base_q;
  int                exp_ch;
  always_ff @(posedge clk) base_q <= bcast_base_i;
  always_comb exp_ch = (int'(base_q) == MODV) ? MODV : ((int'(base_q) + PLUG_IDX) % MODV);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (p2p_count_o == '0 && !bcast_o && !tx_en_o));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p2p_count_o != $past(p2p_count_o)) |->
      (p2p_count_o == $past(p2p_count_o) + 1'b1 ||
       p2p_count_o == $past(p2p_count_o) - 1'b1 || p2p_count_o == '0));

  assert_reject_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject_o |-> ($stable(p2p_count_o) && $stable(bcast_o)));

  assert_bus_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> (p2p_count_o == '0 && !bcast_o && !req_reject_o));

  assert_bchan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bcast_o) && $past(p2p_count_o) == '0) |-> (int'(channel_o) == exp_ch));

  assert_offline_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!online_i) |-> !tx_en_o);

  assert_stop_on_break_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 2'd2 && state_o == 2'd1 && !$past(bus_reset_i)) |-> !tx_en_o);

  assert_speed_ext_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_i != 2'd3 && xspd_i != 2'd0) |-> speed_bad_o);
endmodule

bind iso_plug_ctrl iso_plug_ctrl_chk #(
  .CNT_W(CNT_W), .CHAN_W(CHAN_W), .PLUG_IDX(PLUG_IDX)
) u_chk (.*);

// File: tb/test_iso_plug_ctrl.sv
module test_iso_plug_ctrl;
  localparam int CNT_W  = 6;
  localparam int CHAN_W = 6;
  localparam int IDX    = 5;
  localparam int GRACE  = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid_i;
  logic [1:0]        req_op_i;
  logic [CHAN_W-1:0] req_chan_i;
  logic [CHAN_W-1:0] bcast_base_i;
  logic              online_i;
  logic              bus_reset_i;
  logic              us_tick_i;
  logic [1:0]        spd_i;
  logic [1:0]        xspd_i;
  logic              tx_en_o;
  logic [1:0]        state_o;
  logic [CNT_W-1:0]  p2p_count_o;
  logic              bcast_o;
  logic [CHAN_W-1:0] channel_o;
  logic              req_reject_o;
  logic [2:0]        speed_code_o;
  logic              speed_bad_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  iso_plug_ctrl #(.CNT_W(CNT_W), .CHAN_W(CHAN_W), .PLUG_IDX(IDX), .GRACE_US(GRACE)) i_iso_plug_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_chan_i(req_chan_i), .bcast_base_i(bcast_base_i), .online_i(online_i),
    .bus_reset_i(bus_reset_i), .us_tick_i(us_tick_i), .spd_i(spd_i), .xspd_i(xspd_i),
    .tx_en_o(tx_en_o), .state_o(state_o), .p2p_count_o(p2p_count_o), .bcast_o(bcast_o),
    .channel_o(channel_o), .req_reject_o(req_reject_o), .speed_code_o(speed_code_o),
    .speed_bad_o(speed_bad_o));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input int ch);
    req_valid_i = 1'b1;
    req_op_i    = op;
    req_chan_i  = CHAN_W'(ch);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic pulse_reset_bus();
    bus_reset_i = 1'b1;
    @(negedge clk);
    bus_reset_i = 1'b0;
  endtask

  task automatic tick();
    us_tick_i = 1'b1;
    @(negedge clk);
    us_tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid_i = 1'b0; req_op_i = 2'd0; req_chan_i = '0;
    bcast_base_i = '0; online_i = 1'b0; bus_reset_i = 1'b0; us_tick_i = 1'b0;
    spd_i = 2'd0; xspd_i = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", state_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 count", p2p_count_o, 0);
    chk("R1 bcast", bcast_o, 0);
    chk("R1 tx", tx_en_o, 0);
    chk("R1 reject", req_reject_o, 0);

    // off-line connect -> suspended
    do_req(2'd0, 10);
    chk("R2 suspended", state_o, 3);
    chk("R6 first chan", channel_o, 10);
    chk("R10 no tx off-line", tx_en_o, 0);
    online_i = 1'b1;
    @(negedge clk);
    chk("R10 resume active", state_o, 2);
    chk("R3 tx active", tx_en_o, 1);
    do_req(2'd0, 20);
    chk("R4 count 2", p2p_count_o, 2);
    chk("R6 chan kept", channel_o, 10);
    do_req(2'd1, 0);
    chk("R3 still active", state_o, 2);
    do_req(2'd1, 0);
    chk("R2 ready", state_o, 1);
    chk("R3 tx stops", tx_en_o, 0);
    do_req(2'd1, 0);
    chk("R4 underflow reject", req_reject_o, 1);
    chk("R4 underflow count", p2p_count_o, 0);
    @(negedge clk);
    chk("R4 reject one cycle", req_reject_o, 0);

    // fill to the ceiling
    for (int i = 1; i <= 63; i++) begin
      do_req(2'd0, 33);
      chk("R4 count up", p2p_count_o, i);
    end
    chk("R6 chan from first add", channel_o, 33);
    do_req(2'd0, 1);
    chk("R4 overflow reject", req_reject_o, 1);
    chk("R4 overflow count", p2p_count_o, 63);

    // bus reset with grace window
    pulse_reset_bus();
    chk("R8 count cleared", p2p_count_o, 0);
    chk("R8 chan kept", channel_o, 33);
    chk("R2 ready after bus reset", state_o, 1);
    chk("R9 grace tx", tx_en_o, 1);
    for (int t = 1; t <= GRACE; t++) begin
      tick();
      chk("R9 grace window", tx_en_o, (t < GRACE) ? 1 : 0);
    end

    // request together with bus reset is ignored
    req_valid_i = 1'b1; req_op_i = 2'd0; req_chan_i = 6'd9;
    bus_reset_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0; bus_reset_i = 1'b0;
    chk("R8 request ignored", p2p_count_o, 0);
    chk("R8 no reject", req_reject_o, 0);

    // grace cut by going off-line
    do_req(2'd0, 4);
    pulse_reset_bus();
    chk("R9 grace start", tx_en_o, 1);
    online_i = 1'b0;
    @(negedge clk);
    chk("R9 off-line ends grace", tx_en_o, 0);
    chk("R2 idle", state_o, 0);
    online_i = 1'b1;
    @(negedge clk);
    chk("R9 no grace after return", tx_en_o, 0);

    // broadcast channel sweep
    for (int b = 0; b < 64; b++) begin
      int exp_c;
      exp_c = (b == 63) ? 63 : ((b + IDX) % 63);
      bcast_base_i = CHAN_W'(b);
      do_req(2'd2, 0);
      chk("R7 bcast chan", channel_o, exp_c);
      chk("R5 bcast set", bcast_o, 1);
      chk("R2 bcast active", state_o, 2);
      do_req(2'd2, 0);
      chk("R5 second bcast reject", req_reject_o, 1);
      do_req(2'd3, 0);
      chk("R5 bcast cleared", bcast_o, 0);
      chk("R5 clear accepted", req_reject_o, 0);
    end
    do_req(2'd3, 0);
    chk("R5 clear absent reject", req_reject_o, 1);

    // broadcast joining an existing p2p channel
    do_req(2'd0, 7);
    bcast_base_i = 6'd0;
    do_req(2'd2, 0);
    chk("R6 bcast shares chan", channel_o, 7);

    // speed decode sweep
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 4; x++) begin
        int eb, ec;
        spd_i = 2'(s); xspd_i = 2'(x);
        eb = ((s != 3 && x != 0) || (s == 3 && x == 3)) ? 1 : 0;
        ec = eb ? 7 : ((s == 3) ? 3 + x : s);
        @(negedge clk);
        chk("R11 speed bad", speed_bad_o, eb);
        chk("R11 speed code", speed_code_o, ec);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule